// File: doc/BRIEF.md
# Strap-Addressed Thermal Register Slave for a Two-Wire Bus

This block is the bus-facing side of a temperature monitor. It sits on a two-wire serial bus as a target. The bus master drives the clock line, and data moves in both directions on the data line. The target's 7-bit address has two parts: a fixed upper nibble, and three board-level strap inputs that supply the low bits. Up to eight of these monitors can therefore share one bus. The block samples both bus lines into the system clock domain. It detects START and STOP conditions, and it pulls the data line low whenever it must send a zero or an acknowledge.

Inside the block, an index register chooses one of four registers: the live temperature reading, a configuration byte, and two 16-bit alarm thresholds. In a write transaction, the first data byte loads the index. The bytes after it go to the selected register. A read transaction returns the selected register, high byte first. The register contents themselves are held outside the block. The block reads them through input ports and reports writes through one-cycle strobes.

The block also answers the shared alert-response address while its alarm input is pending. It returns its own address and raises a one-cycle strobe, which the surrounding logic uses to clear the alarm. Register access never depends on any power-saving state held outside the block.

Top module: `thermo_i2c_slave`

## Requirements
- R1: The block acknowledges only the 7-bit address formed as binary 1001 in bits 6..3 and strap_i[2:0] in bits 2..0. It pulls SDA low during the ninth clock of a matching address byte and leaves SDA released for any other address.
- R2: The index register is 0 after reset. Bits [1:0] of the first data byte of a write transaction load the index. The index persists across STOP and repeated START.
- R3: Index code 0 selects the temperature. A read returns temp_i[15:8], then temp_i[7:0]. Every further byte of the same read returns 8'hFF.
- R4: Index code 1 selects the 8-bit configuration. A written byte pulses cfg_wr_o for one cycle with the byte on wr_data_o[7:0]. A read returns cfg_i as one byte, followed by 8'hFF.
- R5: Index codes 2 (hysteresis) and 3 (over-temperature) take a high byte and then a low byte. Only after the low byte, hyst_wr_o or ovt_wr_o pulses for one cycle with {high,low} on wr_data_o. At most one write strobe is high in any cycle.
- R6: Data bytes written while the index is 0 produce no write strobe. Bytes beyond a register's width also produce no write strobe.
- R7: A read to address 7'h0C is acknowledged only while alert_pend_i is high. It returns {own address, 1'b0} and pulses alert_clr_o once when that byte completes. Without a pending alert, the address is not acknowledged.
- R8: After the master does not acknowledge a read byte, the block releases SDA and drives no further data bits.
- R9: The block changes sda_pull_o only after an SCL falling edge, a START or a STOP. It never changes sda_pull_o while SCL is steady high in the middle of a bit.
- R10: A STOP releases SDA and returns the block to idle, even in the middle of a byte. A START, whether repeated or not, begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 3 | Low three address bits from board straps |
| alert_pend_i | input | 1 | Alarm pending; enables the alert-response reply |
| temp_i | input | 16 | Temperature register contents |
| cfg_i | input | 8 | Configuration register contents |
| hyst_i | input | 16 | Hysteresis threshold contents |
| ovt_i | input | 16 | Over-temperature threshold contents |
| sda_pull_o | output | 1 | Pull the data line low when high |
| cfg_wr_o | output | 1 | One-cycle configuration write strobe |
| hyst_wr_o | output | 1 | One-cycle hysteresis write strobe |
| ovt_wr_o | output | 1 | One-cycle over-temperature write strobe |
| wr_data_o | output | 16 | Write data accompanying the strobes |
| alert_clr_o | output | 1 | One-cycle pulse after an alert-response read |

## Verification
The read and write paths are tried with data whose bits differ from byte to byte. A swapped byte order or a shifted bit position therefore shows up at once. Reading the temperature with a low byte whose top bit is zero makes a missed NACK visible, because a slave that kept sending would pull the line. Addresses that differ from the own address in a strap bit, plus a second strap setting, separate a real address compare from a fixed one. The alert-response address is tried with the alarm both low and high, so a reply gated by the alarm can be told apart from one that always answers. A repeated START after an index write, and a STOP in the middle of a byte, show whether the index survives across transactions and whether the state machine restarts cleanly.

// File: rtl/thsl_pkg.sv
package thsl_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_W  = 2 * BYTE_W;
  localparam int IDX_W  = 2;

  localparam logic [3:0] ADDR_HI  = 4'b1001;
  localparam logic [6:0] ARA_ADDR = 7'h0C;

  localparam logic [IDX_W-1:0] SEL_TEMP = 2'd0;
  localparam logic [IDX_W-1:0] SEL_CFG  = 2'd1;
  localparam logic [IDX_W-1:0] SEL_HYST = 2'd2;
  localparam logic [IDX_W-1:0] SEL_OVT  = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WR, ST_WACK, ST_RD, ST_RACK
  } bus_state_t;
endpackage

// File: rtl/thsl_sync.sv
module thsl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_s, scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_s;
      sda_d    <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = ~scl_d & scl_s;
  assign scl_fall  = scl_d & ~scl_s;
  assign start_det = scl_d & scl_s & sda_d & ~sda_s;
  assign stop_det  = scl_d & scl_s & ~sda_d & sda_s;
endmodule

// File: rtl/thsl_rdmux.sv
module thsl_rdmux
  import thsl_pkg::*;
(
  input  logic              ara,
  input  logic [IDX_W-1:0]  sel,
  input  logic [1:0]        idx,
  input  logic [6:0]        own_addr,
  input  logic [REG_W-1:0]  temp,
  input  logic [BYTE_W-1:0] cfg,
  input  logic [REG_W-1:0]  hyst,
  input  logic [REG_W-1:0]  ovt,
  output logic [BYTE_W-1:0] rd_byte
);
  function automatic logic [BYTE_W-1:0] pick16(input logic [REG_W-1:0] v,
                                               input logic [1:0] i);
    case (i)
      2'd0:    return v[REG_W-1:BYTE_W];
      2'd1:    return v[BYTE_W-1:0];
      default: return '1;
    endcase
  endfunction

  always_comb begin
    rd_byte = '1;
    if (ara) begin
      if (idx == 2'd0) rd_byte = {own_addr, 1'b0};
    end else begin
      case (sel)
        SEL_TEMP: rd_byte = pick16(temp, idx);
        SEL_CFG:  rd_byte = (idx == 2'd0) ? cfg : '1;
        SEL_HYST: rd_byte = pick16(hyst, idx);
        default:  rd_byte = pick16(ovt, idx);
      endcase
    end
  end
endmodule

// File: rtl/thermo_i2c_slave.sv
module thermo_i2c_slave
  import thsl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  input  logic              alert_pend_i,
  input  logic [REG_W-1:0]  temp_i,
  input  logic [BYTE_W-1:0] cfg_i,
  input  logic [REG_W-1:0]  hyst_i,
  input  logic [REG_W-1:0]  ovt_i,
  output logic              sda_pull_o,
  output logic              cfg_wr_o,
  output logic              hyst_wr_o,
  output logic              ovt_wr_o,
  output logic [REG_W-1:0]  wr_data_o,
  output logic              alert_clr_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  bus_state_t state_q;
  logic [CNT_W-1:0]  bcnt_q;
  logic [BYTE_W-1:0] sh_q, tx_q, hi_q, rd_byte;
  logic [IDX_W-1:0]  ptr_q;
  logic [1:0]        idx_q, idx_inc, idx_sel;
  logic              rd_q, ara_q, nack_q;
  logic [6:0]        own_addr;

  assign own_addr = {ADDR_HI, strap_i};
  assign idx_inc  = (idx_q == 2'd3) ? idx_q : idx_q + 2'd1;
  assign idx_sel  = (state_q == ST_RACK) ? idx_inc : idx_q;

  thsl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  thsl_rdmux u_rdmux (
    .ara(ara_q), .sel(ptr_q), .idx(idx_sel), .own_addr(own_addr),
    .temp(temp_i), .cfg(cfg_i), .hyst(hyst_i), .ovt(ovt_i),
    .rd_byte(rd_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      bcnt_q      <= '0;
      sh_q        <= '0;
      tx_q        <= '0;
      hi_q        <= '0;
      ptr_q       <= SEL_TEMP;
      idx_q       <= '0;
      rd_q        <= 1'b0;
      ara_q       <= 1'b0;
      nack_q      <= 1'b0;
      sda_pull_o  <= 1'b0;
      cfg_wr_o    <= 1'b0;
      hyst_wr_o   <= 1'b0;
      ovt_wr_o    <= 1'b0;
      wr_data_o   <= '0;
      alert_clr_o <= 1'b0;
    end else begin
      cfg_wr_o    <= 1'b0;
      hyst_wr_o   <= 1'b0;
      ovt_wr_o    <= 1'b0;
      alert_clr_o <= 1'b0;
      if (stop_det) begin
        state_q    <= ST_IDLE;
        sda_pull_o <= 1'b0;
      end else if (start_det) begin
        state_q    <= ST_ADDR;
        bcnt_q     <= '0;
        sda_pull_o <= 1'b0;
      end else begin
        case (state_q)
          ST_ADDR: begin
            if (scl_rise) begin
              sh_q   <= {sh_q[BYTE_W-2:0], sda_s};
              bcnt_q <= bcnt_q + 1'b1;
            end else if (scl_fall && bcnt_q == FULL) begin
              idx_q <= '0;
              if (sh_q[7:1] == own_addr) begin
                rd_q <= sh_q[0]; ara_q <= 1'b0;
                sda_pull_o <= 1'b1; state_q <= ST_AACK;
              end else if (sh_q[7:1] == ARA_ADDR && sh_q[0] && alert_pend_i) begin
                rd_q <= 1'b1; ara_q <= 1'b1;
                sda_pull_o <= 1'b1; state_q <= ST_AACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_AACK: if (scl_fall) begin
            bcnt_q <= '0;
            if (rd_q) begin
              tx_q <= rd_byte; sda_pull_o <= ~rd_byte[7]; state_q <= ST_RD;
            end else begin
              sda_pull_o <= 1'b0; state_q <= ST_WR;
            end
          end
          ST_WR: begin
            if (scl_rise) begin
              sh_q   <= {sh_q[BYTE_W-2:0], sda_s};
              bcnt_q <= bcnt_q + 1'b1;
            end else if (scl_fall && bcnt_q == FULL) begin
              sda_pull_o <= 1'b1;
              state_q    <= ST_WACK;
              idx_q      <= idx_inc;
              case (idx_q)
                2'd0: ptr_q <= sh_q[IDX_W-1:0];
                2'd1: begin
                  if (ptr_q == SEL_CFG) begin
                    cfg_wr_o  <= 1'b1;
                    wr_data_o <= {{BYTE_W{1'b0}}, sh_q};
                  end
                  hi_q <= sh_q;
                end
                2'd2: begin
                  if (ptr_q == SEL_HYST || ptr_q == SEL_OVT) begin
                    hyst_wr_o <= (ptr_q == SEL_HYST);
                    ovt_wr_o  <= (ptr_q == SEL_OVT);
                    wr_data_o <= {hi_q, sh_q};
                  end
                end
                default: ;
              endcase
            end
          end
          ST_WACK: if (scl_fall) begin
            sda_pull_o <= 1'b0; bcnt_q <= '0; state_q <= ST_WR;
          end
          ST_RD: begin
            if (scl_rise) begin
              bcnt_q <= bcnt_q + 1'b1;
            end else if (scl_fall) begin
              if (bcnt_q == FULL) begin
                sda_pull_o <= 1'b0; state_q <= ST_RACK;
              end else begin
                tx_q       <= {tx_q[BYTE_W-2:0], 1'b0};
                sda_pull_o <= ~tx_q[BYTE_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              nack_q <= sda_s;
            end else if (scl_fall) begin
              if (ara_q && idx_q == 2'd0) alert_clr_o <= 1'b1;
              if (nack_q) begin
                state_q <= ST_IDLE;
              end else begin
                idx_q <= idx_inc; tx_q <= rd_byte; bcnt_q <= '0;
                sda_pull_o <= ~rd_byte[7]; state_q <= ST_RD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/thsl_chk.sv
module thsl_chk
  import thsl_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             scl_fall,
  input logic             start_det,
  input logic             stop_det,
  input logic             sda_pull_o,
  input logic             cfg_wr_o,
  input logic             hyst_wr_o,
  input logic             ovt_wr_o,
  input logic             alert_clr_o,
  input logic [IDX_W-1:0] ptr_q
);
  a_r9_pull_moves_on_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_pull_o) |-> $past(scl_fall || start_det || stop_det));

  a_r10_stop_releases: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_pull_o);

  a_r5_single_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cfg_wr_o, hyst_wr_o, ovt_wr_o}));

  a_r4_strobe_after_fall: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr_o || hyst_wr_o || ovt_wr_o) |-> $past(scl_fall));

  a_r7_clear_after_fall: assert property (@(posedge clk) disable iff (rst)
    alert_clr_o |-> $past(scl_fall));

  a_r2_index_reset: assert property (@(posedge clk)
    $past(rst) |-> ptr_q == SEL_TEMP);
endmodule

bind thermo_i2c_slave thsl_chk u_chk (
  .clk(clk), .rst(rst), .scl_fall(scl_fall), .start_det(start_det),
  .stop_det(stop_det), .sda_pull_o(sda_pull_o), .cfg_wr_o(cfg_wr_o),
  .hyst_wr_o(hyst_wr_o), .ovt_wr_o(ovt_wr_o), .alert_clr_o(alert_clr_o),
  .ptr_q(ptr_q)
);

// File: tb/thermo_i2c_slave_tb.sv
`timescale 1ns/1ps
module thermo_i2c_slave_tb;
  localparam int Q = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic alert = 1'b0;
  logic [15:0] temp = 16'hA53C, hyst = 16'h4B00, ovt = 16'h5080;
  logic [7:0] cfg = 8'hC3;
  logic sda_pull, cfg_wr, hyst_wr, ovt_wr, alert_clr;
  logic [15:0] wr_data;
  wire sda_line = sda_m & ~sda_pull;

  int checks = 0, fails = 0;
  int cfg_cnt = 0, hyst_cnt = 0, ovt_cnt = 0, clr_cnt = 0, r9_bad = 0;
  logic [15:0] last_data = '0;
  logic prev_pull = 1'b0;

  always #4 clk = ~clk;

  thermo_i2c_slave u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .strap_i(strap),
    .alert_pend_i(alert), .temp_i(temp), .cfg_i(cfg), .hyst_i(hyst),
    .ovt_i(ovt), .sda_pull_o(sda_pull), .cfg_wr_o(cfg_wr),
    .hyst_wr_o(hyst_wr), .ovt_wr_o(ovt_wr), .wr_data_o(wr_data),
    .alert_clr_o(alert_clr)
  );

  always @(posedge clk) begin
    if (cfg_wr)    begin cfg_cnt++;  last_data = wr_data; end
    if (hyst_wr)   begin hyst_cnt++; last_data = wr_data; end
    if (ovt_wr)    begin ovt_cnt++;  last_data = wr_data; end
    if (alert_clr) clr_cnt++;
    if (!rst && sda_pull !== prev_pull && scl_m) r9_bad++;
    prev_pull = sda_pull;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bit_x(input logic b, output logic r);
    sda_m = b; q(); scl_m = 1'b1; q(); r = sda_line; q(); scl_m = 1'b0; q();
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_x(d[i], r);
    bit_x(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) bit_x(1'b1, d[i]);
    bit_x(~give_ack, r);
  endtask

  task automatic t_reset();
    chk(sda_pull == 1'b0, "R10 reset pull", sda_pull, 0);
    chk(cfg_cnt + hyst_cnt + ovt_cnt == 0, "R6 reset strobes", cfg_cnt, 0);
  endtask

  task automatic t_read_temp();
    logic a; logic [7:0] d;
    bus_start(); send_byte(8'h9B, a);
    chk(a, "R1 own address ack", a, 1);
    recv_byte(1'b1, d); chk(d == 8'hA5, "R2 R3 temp high byte", d, 8'hA5);
    recv_byte(1'b1, d); chk(d == 8'h3C, "R3 temp low byte", d, 8'h3C);
    recv_byte(1'b0, d); chk(d == 8'hFF, "R3 extra byte", d, 8'hFF);
    bus_stop();
  endtask

  task automatic t_addr();
    logic a; logic [7:0] d;
    bus_start(); send_byte(8'h9C, a); bus_stop();
    chk(!a, "R1 foreign address", a, 0);
    bus_start(); send_byte(8'h8B, a); bus_stop();
    chk(!a, "R1 wrong upper nibble", a, 0);
    strap = 3'b010;
    bus_start(); send_byte(8'h95, a);
    chk(a, "R1 other strap ack", a, 1);
    recv_byte(1'b0, d); bus_stop();
    chk(d == 8'hA5, "R1 other strap read", d, 8'hA5);
    strap = 3'b101;
  endtask

  task automatic t_cfg();
    logic a; logic [7:0] d;
    bus_start(); send_byte(8'h9A, a); send_byte(8'h01, a); send_byte(8'h5A, a); bus_stop();
    chk(cfg_cnt == 1, "R4 cfg strobe count", cfg_cnt, 1);
    chk(last_data[7:0] == 8'h5A, "R4 cfg data", last_data, 8'h5A);
    bus_start(); send_byte(8'h9B, a);
    recv_byte(1'b1, d); chk(d == 8'hC3, "R4 cfg read", d, 8'hC3);
    recv_byte(1'b0, d); chk(d == 8'hFF, "R4 cfg single byte", d, 8'hFF);
    bus_stop();
  endtask

  task automatic t_thresh();
    logic a; logic [7:0] d;
    bus_start(); send_byte(8'h9A, a); send_byte(8'h02, a); send_byte(8'h12, a);
    chk(hyst_cnt == 0, "R5 no strobe after high byte", hyst_cnt, 0);
    send_byte(8'h34, a); bus_stop();
    chk(hyst_cnt == 1 && last_data == 16'h1234, "R5 hysteresis write", last_data, 16'h1234);
    bus_start(); send_byte(8'h9A, a); send_byte(8'h03, a); send_byte(8'h56, a);
    send_byte(8'h78, a); bus_stop();
    chk(ovt_cnt == 1 && last_data == 16'h5678, "R5 over-temp write", last_data, 16'h5678);
    chk(hyst_cnt == 1, "R5 hysteresis untouched", hyst_cnt, 1);
    bus_start(); send_byte(8'h9A, a); send_byte(8'h03, a);
    bus_start(); send_byte(8'h9B, a);
    recv_byte(1'b1, d); chk(d == 8'h50, "R10 R2 repeated start high", d, 8'h50);
    recv_byte(1'b0, d); chk(d == 8'h80, "R10 repeated start low", d, 8'h80);
    bus_stop();
  endtask

  task automatic t_temp_wr();
    logic a;
    bus_start(); send_byte(8'h9A, a); send_byte(8'h00, a); send_byte(8'h77, a);
    send_byte(8'h88, a); send_byte(8'h99, a); bus_stop();
    chk(cfg_cnt + hyst_cnt + ovt_cnt == 3, "R6 temperature write ignored",
        cfg_cnt + hyst_cnt + ovt_cnt, 3);
  endtask

  task automatic t_ara();
    logic a; logic [7:0] d;
    bus_start(); send_byte(8'h19, a); bus_stop();
    chk(!a, "R7 no alert no ack", a, 0);
    alert = 1'b1;
    bus_start(); send_byte(8'h19, a);
    chk(a, "R7 alert ack", a, 1);
    recv_byte(1'b0, d); bus_stop();
    chk(d == 8'h9A, "R7 own address returned", d, 8'h9A);
    chk(clr_cnt == 1, "R7 clear pulse", clr_cnt, 1);
    alert = 1'b0;
  endtask

  task automatic t_nack();
    logic a, r; logic [7:0] d;
    bus_start(); send_byte(8'h9A, a); send_byte(8'h00, a);
    bus_start(); send_byte(8'h9B, a); recv_byte(1'b0, d);
    chk(sda_pull == 1'b0, "R8 released after nack", sda_pull, 0);
    bit_x(1'b1, r);
    chk(r == 1'b1, "R8 no further data", r, 1);
    bus_stop();
  endtask

  task automatic t_stop_mid();
    logic a, r; logic [7:0] d;
    bus_start(); send_byte(8'h9A, a);
    for (int i = 0; i < 4; i++) bit_x(1'b0, r);
    bus_stop();
    chk(sda_pull == 1'b0, "R10 stop mid byte", sda_pull, 0);
    bus_start(); send_byte(8'h9B, a); recv_byte(1'b0, d); bus_stop();
    chk(a && d == 8'hA5, "R10 clean restart", d, 8'hA5);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    q();
    t_reset();
    t_read_temp();
    t_addr();
    t_cfg();
    t_thresh();
    t_temp_wr();
    t_ara();
    t_nack();
    t_stop_mid();
    chk(r9_bad == 0, "R9 pull changed with SCL high", r9_bad, 0);
    summary();
  end
endmodule